// File: doc/BRIEF.md
# Line-Granular Instruction Fetch Unit

This block feeds a decoder with whole cache lines of instruction words for a small accumulator machine. Its 15-bit addresses hold a 3-bit field number above a 12-bit offset within the field. The unit keeps a fetch address and a generation tag. Each line is 8 words of 12 bits, and the unit holds them in an 8-set, 2-way instruction cache. When the current address hits and the downstream buffer has room, the unit pushes a bundle in that same cycle. The bundle carries the full line, the fetch address and the generation tag. The address then steps to the start of the next line. That step wraps inside the 12-bit field and leaves the field bits unchanged.

When the address misses, the unit asks for the line on a shared memory command port. It never has more than one fill outstanding. A fill response can arrive on the response port in any cycle, and it is written into the cache. A restart loads a new address and a new generation tag. It clears the outstanding fill and takes priority over any emission or request in the same cycle.

The fill tracker is a two-state machine. `FS_IDLE` means no fill is outstanding, and `FS_WAIT` means one fill is in flight. The transition `ISSUE` (FS_IDLE to FS_WAIT) happens when a request is sent. The transition `RELEASE` (FS_WAIT to FS_IDLE) happens on a restart or on a bundle emission. In every other cycle the machine holds its state.

Top module: `ifu_line_fetch`

## Requirements
- R1: After reset the fetch address is 0 and the generation tag is 0, both visible on `bundle_addr` and `bundle_gen`. No bundle and no command are offered. The first request carries line address 0.
- R2: `cmd_valid` is high only when no fill is outstanding, `cmd_ready` is high, the current address misses and no restart is present. `cmd_line` equals the fetch address shifted right by 3.
- R3: A request is never followed by a second one until a restart or a bundle emission has released the outstanding fill.
- R4: A fill response (`rsp_valid` with `rsp_line` and `rsp_data`) is installed at the clock edge. From the next cycle that line hits. Word i of a line occupies bits [12*i+11:12*i] of the data vector.
- R5: `bundle_valid` is high only when `bundle_ready` is high, the current address hits and no restart is present. The bundle carries the line data, the fetch address and the generation tag.
- R6: After an emission the address becomes {field bits unchanged, line-in-field + 1 modulo 512, offset 0}. For example, octal 37774 goes to octal 30000.
- R7: A restart replaces the address and the generation tag at the clock edge and clears the outstanding fill. In its own cycle it suppresses both `bundle_valid` and `cmd_valid`.
- R8: A fill response that arrives after a restart has abandoned its request is still installed and later hits.
- R9: The set index is line address bits [2:0]. Each set keeps one LRU bit. A fill goes into the least recently used way, and a hit emission marks its way as recently used.
- R10: A fill for a line that is already cached overwrites that way rather than creating a second copy.
- R11: A bundle emission releases the outstanding fill, so the next line can be requested in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart_valid | input | 1 | Restart request |
| restart_addr | input | 15 | New fetch address |
| restart_gen | input | 4 | New generation tag |
| bundle_ready | input | 1 | Downstream buffer has room |
| bundle_valid | output | 1 | Bundle pushed this cycle |
| bundle_addr | output | 15 | Current fetch address |
| bundle_gen | output | 4 | Current generation tag |
| bundle_data | output | 96 | Cached line, word 0 in the low bits |
| cmd_ready | input | 1 | Memory command port can accept |
| cmd_valid | output | 1 | Line-fill request this cycle |
| cmd_line | output | 12 | Line address of the request |
| rsp_valid | input | 1 | Fill response present |
| rsp_line | input | 12 | Line address of the response |
| rsp_data | input | 96 | Line data of the response |

## Verification
Each kind of corrupted internal state shows up at the ports at a known time:

- **Fill tracker stuck in `FS_WAIT`.** No further request appears for a missing line, and this is visible in the cycle after a release.
- **Fill tracker stuck in `FS_IDLE`.** Requests repeat in back-to-back cycles.
- **Wrong next-line address or lost field bits.** The error appears on `cmd_line` or `bundle_addr` one cycle after an emission.
- **Wrong LRU bit or wrong duplicate handling.** Nothing shows until a later probe of an evicted or refilled line. That probe then produces a request where a hit was expected, or returns stale data.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    // Default geometry of the fetch unit
    localparam int ADDR_W_D     = 15;
    localparam int OFFS_W_D     = 12;
    localparam int WORD_W_D     = 12;
    localparam int LINE_WORDS_D = 8;
    localparam int SETS_D       = 8;
    localparam int GEN_W_D      = 4;

    // Fill tracker states
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fill_state_e;

endpackage

// File: rtl/ifu_pc_gen.sv
module ifu_pc_gen #(
    parameter int ADDR_W     = 15,
    parameter int OFFS_W     = 12,
    parameter int LOFF_W     = 3,
    parameter int GEN_W      = 4,
    parameter int RESET_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_addr,
    input  logic [GEN_W-1:0]  restart_gen,
    input  logic              advance,
    output logic [ADDR_W-1:0] pc,
    output logic [GEN_W-1:0]  gen
);
    localparam int LIF_W = OFFS_W - LOFF_W;
    localparam logic [LIF_W-1:0] ONE_LINE = LIF_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [GEN_W-1:0]  gen_q;
    logic [LIF_W-1:0]  line_in_field;
    logic [ADDR_W-1:0] pc_next_line;

    // Step to the next line start, wrapping inside the field
    assign line_in_field = pc_q[OFFS_W-1:LOFF_W];
    assign pc_next_line  = {pc_q[ADDR_W-1:OFFS_W], line_in_field + ONE_LINE, {LOFF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= ADDR_W'(RESET_ADDR);
            gen_q <= '0;
        end else if (restart) begin
            pc_q  <= restart_addr;
            gen_q <= restart_gen;
        end else if (advance) begin
            pc_q  <= pc_next_line;
        end
    end

    assign pc  = pc_q;
    assign gen = gen_q;
endmodule

// File: rtl/ifu_line_store.sv
module ifu_line_store #(
    parameter int LINE_AW   = 12,
    parameter int SETS      = 8,
    parameter int LINE_BITS = 96
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINE_AW-1:0]   lk_line,
    output logic                 lk_hit,
    output logic [LINE_BITS-1:0] lk_data,
    input  logic                 touch,
    input  logic                 fl_en,
    input  logic [LINE_AW-1:0]   fl_line,
    input  logic [LINE_BITS-1:0] fl_data
);
    localparam int WAYS  = 2;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = LINE_AW - SET_W;

    logic [TAG_W-1:0]     tag_q [SETS][WAYS];
    logic [LINE_BITS-1:0] dat_q [SETS][WAYS];
    logic [WAYS-1:0]      vld_q [SETS];
    logic [SETS-1:0]      lru_q;   // way to replace next

    logic [SET_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    logic [WAYS-1:0]  lk_match, fl_match;
    logic             lk_way, fl_way;

    assign lk_set = lk_line[SET_W-1:0];
    assign lk_tag = lk_line[LINE_AW-1:SET_W];
    assign fl_set = fl_line[SET_W-1:0];
    assign fl_tag = fl_line[LINE_AW-1:SET_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        assign fl_match[w] = vld_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag);
    end

    assign lk_hit  = |lk_match;
    assign lk_way  = lk_match[1];
    assign lk_data = dat_q[lk_set][lk_way];

    // Refill an existing copy in place, else take the LRU victim
    assign fl_way = (|fl_match) ? fl_match[1] : lru_q[fl_set];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (touch && !(fl_en && (fl_set == lk_set))) begin
                lru_q[lk_set] <= ~lk_way;
            end
            if (fl_en) begin
                vld_q[fl_set][fl_way] <= 1'b1;
                lru_q[fl_set]         <= ~fl_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fl_en) begin
            tag_q[fl_set][fl_way] <= fl_tag;
            dat_q[fl_set][fl_way] <= fl_data;
        end
    end
endmodule

// File: rtl/ifu_fill_ctl.sv
module ifu_fill_ctl
    import ifu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic emit,
    input  logic hit,
    input  logic cmd_ready,
    output logic cmd_valid
);
    fill_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ISSUE and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: if (cmd_valid)       state_d = FS_WAIT;
            FS_WAIT: if (restart || emit) state_d = FS_IDLE;
            default:                      state_d = FS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_valid = 1'b0;
        unique case (state_q)
            FS_IDLE: cmd_valid = !restart && cmd_ready && !hit;
            FS_WAIT: cmd_valid = 1'b0;
            default: cmd_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ifu_line_fetch.sv
module ifu_line_fetch #(
    parameter int ADDR_W     = ifu_pkg::ADDR_W_D,
    parameter int OFFS_W     = ifu_pkg::OFFS_W_D,
    parameter int WORD_W     = ifu_pkg::WORD_W_D,
    parameter int LINE_WORDS = ifu_pkg::LINE_WORDS_D,
    parameter int SETS       = ifu_pkg::SETS_D,
    parameter int GEN_W      = ifu_pkg::GEN_W_D,
    parameter int RESET_ADDR = 0,
    localparam int LOFF_W    = $clog2(LINE_WORDS),
    localparam int LINE_AW   = ADDR_W - LOFF_W,
    localparam int LINE_BITS = LINE_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_valid,
    input  logic [ADDR_W-1:0]    restart_addr,
    input  logic [GEN_W-1:0]     restart_gen,
    input  logic                 bundle_ready,
    output logic                 bundle_valid,
    output logic [ADDR_W-1:0]    bundle_addr,
    output logic [GEN_W-1:0]     bundle_gen,
    output logic [LINE_BITS-1:0] bundle_data,
    input  logic                 cmd_ready,
    output logic                 cmd_valid,
    output logic [LINE_AW-1:0]   cmd_line,
    input  logic                 rsp_valid,
    input  logic [LINE_AW-1:0]   rsp_line,
    input  logic [LINE_BITS-1:0] rsp_data
);
    logic [ADDR_W-1:0]  pc;
    logic [GEN_W-1:0]   gen;
    logic [LINE_AW-1:0] pc_line;
    logic               hit;
    logic               emit;

    assign pc_line = pc[ADDR_W-1:LOFF_W];
    assign emit    = !restart_valid && bundle_ready && hit;

    ifu_pc_gen #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LOFF_W(LOFF_W),
        .GEN_W(GEN_W), .RESET_ADDR(RESET_ADDR)
    ) u_pc (
        .clk(clk), .rst_n(rst_n),
        .restart(restart_valid), .restart_addr(restart_addr), .restart_gen(restart_gen),
        .advance(emit), .pc(pc), .gen(gen)
    );

    ifu_line_store #(
        .LINE_AW(LINE_AW), .SETS(SETS), .LINE_BITS(LINE_BITS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_line(pc_line), .lk_hit(hit), .lk_data(bundle_data),
        .touch(emit),
        .fl_en(rsp_valid), .fl_line(rsp_line), .fl_data(rsp_data)
    );

    ifu_fill_ctl u_fill (
        .clk(clk), .rst_n(rst_n),
        .restart(restart_valid), .emit(emit), .hit(hit),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid)
    );

    assign bundle_valid = emit;
    assign bundle_addr  = pc;
    assign bundle_gen   = gen;
    assign cmd_line     = pc_line;
endmodule

// File: rtl/ifu_line_fetch_checker.sv
module ifu_line_fetch_checker #(
    parameter int ADDR_W = 15,
    parameter int OFFS_W = 12,
    parameter int LOFF_W = 3,
    parameter int GEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart_valid,
    input logic              bundle_ready,
    input logic              bundle_valid,
    input logic [ADDR_W-1:0] bundle_addr,
    input logic [GEN_W-1:0]  bundle_gen,
    input logic              cmd_ready,
    input logic              cmd_valid
);
    localparam int LIF_W = OFFS_W - LOFF_W;
    localparam logic [LIF_W-1:0] ONE_LINE = LIF_W'(1);

    AST_CMD_NEEDS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_ready);  // R2

    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && bundle_valid));  // R2

    AST_SINGLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);  // R3

    AST_BUNDLE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_valid |-> bundle_ready);  // R5

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> (!bundle_valid && !cmd_valid));  // R7

    AST_NEXT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_valid |=> (restart_valid || !bundle_valid ||
            bundle_addr == {$past(bundle_addr[ADDR_W-1:OFFS_W]),
                            $past(bundle_addr[OFFS_W-1:LOFF_W]) + ONE_LINE,
                            {LOFF_W{1'b0}}}));  // R6

    AST_GEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_valid |=> (restart_valid || !bundle_valid || bundle_gen == $past(bundle_gen)));  // R7
endmodule

bind ifu_line_fetch ifu_line_fetch_checker #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LOFF_W(LOFF_W), .GEN_W(GEN_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .restart_valid(restart_valid),
    .bundle_ready(bundle_ready), .bundle_valid(bundle_valid),
    .bundle_addr(bundle_addr), .bundle_gen(bundle_gen),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid)
);

// File: tb/ifu_line_fetch_bench.sv
module ifu_line_fetch_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        restart_valid;
    logic [14:0] restart_addr;
    logic [3:0]  restart_gen;
    logic        bundle_ready;
    logic        bundle_valid;
    logic [14:0] bundle_addr;
    logic [3:0]  bundle_gen;
    logic [95:0] bundle_data;
    logic        cmd_ready;
    logic        cmd_valid;
    logic [11:0] cmd_line;
    logic        rsp_valid;
    logic [11:0] rsp_line;
    logic [95:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifu_line_fetch u_ifu_line_fetch (
        .clk(clk), .rst_n(rst_n),
        .restart_valid(restart_valid), .restart_addr(restart_addr), .restart_gen(restart_gen),
        .bundle_ready(bundle_ready), .bundle_valid(bundle_valid), .bundle_addr(bundle_addr),
        .bundle_gen(bundle_gen), .bundle_data(bundle_data),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_line(cmd_line),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_data(rsp_data)
    );

    function automatic logic [95:0] pat(input int ln, input int salt);
        logic [95:0] v;
        for (int i = 0; i < 8; i++) v[12*i +: 12] = 12'((ln * 8 + i) * 3 + salt * 101);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_restart(input logic [14:0] a, input logic [3:0] g);
        restart_valid = 1'b1; restart_addr = a; restart_gen = g;
        bundle_ready = 1'b1; cmd_ready = 1'b1;
        #1;
        chk(!bundle_valid && !cmd_valid, "R7 restart suppresses outputs",
            {bundle_valid, cmd_valid}, 0);
        next_cycle();
        restart_valid = 1'b0; bundle_ready = 1'b0; cmd_ready = 1'b0;
        #1;
        chk(bundle_addr == a && bundle_gen == g, "R7 restart loads addr/gen",
            {bundle_addr, bundle_gen}, {a, g});
    endtask

    task automatic expect_cmd(input logic [11:0] ln, input string req);
        cmd_ready = 1'b1;
        #1;
        chk(cmd_valid && cmd_line == ln, req, {cmd_valid, cmd_line}, {1'b1, ln});
        next_cycle();
        #1;
        chk(!cmd_valid, "R3 no second request while outstanding", cmd_valid, 0);
        cmd_ready = 1'b0;
    endtask

    task automatic send_fill(input logic [11:0] ln, input int salt);
        rsp_valid = 1'b1; rsp_line = ln; rsp_data = pat(ln, salt);
        next_cycle();
        rsp_valid = 1'b0;
    endtask

    task automatic expect_bundle(input logic [14:0] a, input logic [3:0] g,
                                 input logic [95:0] d, input string req);
        bundle_ready = 1'b0;
        #1;
        chk(!bundle_valid, "R5 no bundle without room", bundle_valid, 0);
        bundle_ready = 1'b1;
        #1;
        chk(bundle_valid, req, bundle_valid, 1);
        chk(bundle_addr == a && bundle_gen == g, req, {bundle_addr, bundle_gen}, {a, g});
        chk(bundle_data == d, req, bundle_data, d);
        next_cycle();
        bundle_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; restart_valid = 1'b0; restart_addr = '0; restart_gen = '0;
        bundle_ready = 1'b1; cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_line = '0; rsp_data = '0;
        repeat (3) next_cycle();
        rst_n = 1'b1;
        #1;
        chk(!bundle_valid && !cmd_valid, "R1 idle after reset", {bundle_valid, cmd_valid}, 0);
        chk(bundle_addr == 0 && bundle_gen == 0, "R1 reset addr/gen", {bundle_addr, bundle_gen}, 0);
        bundle_ready = 1'b0;
        expect_cmd(12'd0, "R1 R2 first request line 0");
    endtask

    task automatic t_fill_emit();
        send_fill(12'd0, 1);
        expect_bundle(15'd0, 4'd0, pat(0, 1), "R4 R5 bundle after fill");
        expect_cmd(12'd1, "R11 R6 request for next line after emission");
    endtask

    task automatic t_restart_wrap();
        do_restart(15'o37774, 4'd5);
        expect_cmd(12'o3777, "R7 restart clears outstanding");
        send_fill(12'd1, 2);                       // stale response
        send_fill(12'o3777, 3);
        expect_bundle(15'o37774, 4'd5, pat(12'o3777, 3), "R5 bundle at restart address");
        expect_cmd(12'o3000, "R6 wrap inside field");
        do_restart(15'd8, 4'd6);
        cmd_ready = 1'b1;
        #1;
        chk(!cmd_valid, "R8 stale fill hits, no request", cmd_valid, 0);
        cmd_ready = 1'b0;
        expect_bundle(15'd8, 4'd6, pat(1, 2), "R8 stale fill installed");
    endtask

    task automatic t_lru();
        do_restart(15'd16, 4'd7);  expect_cmd(12'd2,  "R2 miss line 2");  send_fill(12'd2, 4);
        do_restart(15'd80, 4'd7);  expect_cmd(12'd10, "R2 miss line 10"); send_fill(12'd10, 5);
        do_restart(15'd16, 4'd7);
        expect_bundle(15'd16, 4'd7, pat(2, 4), "R9 line 2 present");
        do_restart(15'd144, 4'd7); expect_cmd(12'd18, "R2 miss line 18"); send_fill(12'd18, 6);
        do_restart(15'd16, 4'd7);
        expect_bundle(15'd16, 4'd7, pat(2, 4), "R9 recently used line kept");
        do_restart(15'd144, 4'd7);
        expect_bundle(15'd144, 4'd7, pat(18, 6), "R9 new line present");
        do_restart(15'd80, 4'd7);
        expect_cmd(12'd10, "R9 LRU line evicted");
    endtask

    task automatic t_dup();
        do_restart(15'd24, 4'd8);
        expect_cmd(12'd3, "R2 miss line 3");
        send_fill(12'd3, 7);
        send_fill(12'd3, 9);
        do_restart(15'd24, 4'd8);
        expect_bundle(15'd24, 4'd8, pat(3, 9), "R10 refill replaces copy");
    endtask

    initial begin
        t_reset();
        t_fill_emit();
        t_restart_wrap();
        t_lru();
        t_dup();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule